// File: doc/BRIEF.md
# Phase Comparator with Lock Detect and Monitor Select

This block compares two divided pulse trains, one from the reference path and one from the oscillator feedback path, and drives pump-up and pump-down pulses toward a charge pump. It is a tri-state phase-frequency detector. A rising edge on the reference opens a pump-up pulse and a rising edge on the feedback opens a pump-down pulse. When both have been seen, the pending pulse closes. Each such closing is one comparison. Both divided inputs are sampled on the block clock, so pulse widths are whole clock cycles.

A lock qualifier counts consecutive comparisons whose pulse stays narrower than a programmable width limit. After a programmable run length it raises the lock flag. A polarity pin swaps the sense of the pump outputs for loops with inverted tuning. The same pin picks which divided input is offered as a monitor. A select pin routes either that monitor or the lock flag to one shared output. A power-on pin held low parks the block: pump outputs go quiet, the lock history is dropped and the shared output is held low.

The block has no streaming data path. Every pin is a plain level-sensitive control or status signal, so there is no valid/ready handshake and no back-pressure.

Top module: `phase_cmp_lockmon`

## Requirements
- R1: With the polarity pin high, a rising edge on `ref_div` raises `pump_up` one clock later. `pump_up` stays high for exactly as many cycles as the feedback edge trails it. A rising edge on `vco_div` gives the mirror behaviour on `pump_dn`. Edges sampled in the same cycle produce no pulse.
- R2: `pump_up` and `pump_dn` are never high in the same cycle.
- R3: With the polarity pin low, the pulses of R1 appear on the opposite pump output: a leading reference edge drives `pump_dn` and a leading feedback edge drives `pump_up`.
- R4: A change on the polarity pin is taken only while no pulse is open. A pulse already open keeps the output it started on, and the new sense applies from the next comparison.
- R5: `lock_o` rises when `cfg_lock_len` consecutive comparisons have each had a pulse width below `cfg_width_max` cycles. Coincident edges count as width 0.
- R6: A pulse that reaches `cfg_width_max` cycles clears `lock_o` and restarts the run count. A width of `cfg_width_max`-1 is still a good comparison.
- R7: While `pwr_on` is low, `pump_up`, `pump_dn`, `lock_o` and `shared_o` are low and input edges open no pulse. After `pwr_on` returns high, the lock run starts again from zero.
- R8: With `mon_sel` high, `shared_o` shows the sampled `ref_div` level when the polarity in use is high and the sampled `vco_div` level when it is low. With `mon_sel` low, `shared_o` equals `lock_o`.
- R9: After reset, `pump_up`, `pump_dn` and `lock_o` are low and the polarity in use is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_div | input | 1 | Divided reference pulse train |
| vco_div | input | 1 | Divided feedback pulse train |
| pol_sel | input | 1 | Polarity: high = normal sense; also selects the monitor source |
| mon_sel | input | 1 | High routes the monitor to `shared_o`; low routes the lock flag |
| pwr_on | input | 1 | Low parks the block in power save |
| cfg_width_max | input | CNT_W | Pulse width, in cycles, that counts as a violation |
| cfg_lock_len | input | LOCK_W | Good comparisons in a row needed for lock |
| pump_up | output | 1 | Pump-up pulse |
| pump_dn | output | 1 | Pump-down pulse |
| lock_o | output | 1 | Lock flag |
| shared_o | output | 1 | Monitor or lock, chosen by `mon_sel` |

## Verification
A wrong pulse register shows on a pump output in the cycle after the offending edge. Such a fault also appears as a pulse count that differs from the edge separation by the end of that comparison. A wrong run counter in the qualifier only shows when the lock flag rises one comparison early or late, so the bench counts comparisons up to and across the lock threshold. A stale polarity latch shows on the first pulse after a polarity change, which may be a full comparison later. A retained pulse after power save shows within one cycle of the block waking up.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
package pfd_pkg;
  typedef struct packed {
    logic up;
    logic dn;
  } pump_t;

  localparam pump_t PUMP_IDLE = '{up: 1'b0, dn: 1'b0};
endpackage

// File: rtl/pfd_edge_core.sv
`timescale 1ns/1ps
module pfd_edge_core #(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic              ref_in,
  input  logic              vco_in,
  output pfd_pkg::pump_t    pump,
  output logic              busy,
  output logic              ref_lvl,
  output logic              vco_lvl,
  output logic              cmp_done,
  output logic [CNT_W:0]    cmp_width
);
  import pfd_pkg::*;

  logic             ref_q, vco_q;
  logic             ref_rise, vco_rise;
  logic             up_set, dn_set, meet;
  pump_t            pump_q, pump_d;
  logic [CNT_W-1:0] wid_q;
  logic             wid_sat;
  logic             busy_d;

  assign ref_rise = ref_in & ~ref_q;
  assign vco_rise = vco_in & ~vco_q;
  assign up_set   = pump_q.up | ref_rise;
  assign dn_set   = pump_q.dn | vco_rise;
  assign meet     = up_set & dn_set;

  always_comb begin
    pump_d    = PUMP_IDLE;
    if (pwr_on && !meet) begin
      pump_d.up = up_set;
      pump_d.dn = dn_set;
    end
  end

  assign busy     = pump_q.up | pump_q.dn;
  assign busy_d   = pump_d.up | pump_d.dn;
  assign wid_sat  = &wid_q;
  assign cmp_done = pwr_on & meet;
  assign cmp_width = busy ? ({1'b0, wid_q} + 1'b1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      vco_q  <= 1'b0;
      pump_q <= PUMP_IDLE;
      wid_q  <= '0;
    end else begin
      ref_q  <= ref_in;
      vco_q  <= vco_in;
      pump_q <= pump_d;
      if (busy && busy_d) begin
        if (!wid_sat) wid_q <= wid_q + 1'b1;
      end else begin
        wid_q <= '0;
      end
    end
  end

  assign pump    = pump_q;
  assign ref_lvl = ref_q;
  assign vco_lvl = vco_q;

  AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_q.up && pump_q.dn)); // R2
  AST_UP_FROM_REF_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pump_q.up) |-> ($past(ref_in) && !$past(ref_q))); // R1
  AST_PSAVE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> (!pump_q.up && !pump_q.dn)); // R7
endmodule

// File: rtl/pfd_lock_qual.sv
`timescale 1ns/1ps
module pfd_lock_qual #(
  parameter int CNT_W  = 8,
  parameter int LOCK_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic              busy,
  input  logic              cmp_done,
  input  logic [CNT_W:0]    cmp_width,
  input  logic [CNT_W-1:0]  width_max,
  input  logic [LOCK_W-1:0] run_len,
  output logic              lock_o
);
  logic [LOCK_W-1:0] run_q;
  logic [LOCK_W:0]   run_next;
  logic              viol, good;

  assign viol     = busy & (cmp_width >= {1'b0, width_max});
  assign good     = cmp_done & ~viol;
  assign run_next = {1'b0, run_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      lock_o <= 1'b0;
    end else if (!pwr_on || viol) begin
      run_q  <= '0;
      lock_o <= 1'b0;
    end else if (good) begin
      if (run_next >= {1'b0, run_len}) lock_o <= 1'b1;
      if (!(&run_q)) run_q <= run_next[LOCK_W-1:0];
    end
  end

  AST_LOCK_AFTER_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(cmp_done)); // R5
  AST_WIDE_PULSE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cmp_width > {1'b0, width_max})) |=> !lock_o); // R6
  AST_PSAVE_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> !lock_o); // R7
endmodule

// File: rtl/pfd_out_sel.sv
`timescale 1ns/1ps
module pfd_out_sel (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pwr_on,
  input  logic           pol_sel,
  input  logic           mon_sel,
  input  logic           busy,
  input  pfd_pkg::pump_t pump,
  input  logic           ref_lvl,
  input  logic           vco_lvl,
  input  logic           lock_in,
  output logic           pump_up,
  output logic           pump_dn,
  output logic           shared_o
);
  logic pol_q;
  logic mon;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pol_q <= 1'b1;
    else if (!busy) pol_q <= pol_sel;
  end

  assign mon      = pol_q ? ref_lvl : vco_lvl;
  assign pump_up  = pwr_on & (pol_q ? pump.up : pump.dn);
  assign pump_dn  = pwr_on & (pol_q ? pump.dn : pump.up);
  assign shared_o = pwr_on & (mon_sel ? mon : lock_in);

  AST_POL_HELD_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pol_q)); // R4
endmodule

// File: rtl/phase_cmp_lockmon.sv
`timescale 1ns/1ps
module phase_cmp_lockmon #(
  parameter int CNT_W  = 8,
  parameter int LOCK_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_div,
  input  logic              vco_div,
  input  logic              pol_sel,
  input  logic              mon_sel,
  input  logic              pwr_on,
  input  logic [CNT_W-1:0]  cfg_width_max,
  input  logic [LOCK_W-1:0] cfg_lock_len,
  output logic              pump_up,
  output logic              pump_dn,
  output logic              lock_o,
  output logic              shared_o
);
  pfd_pkg::pump_t   pump;
  logic             busy, ref_lvl, vco_lvl, cmp_done;
  logic [CNT_W:0]   cmp_width;

  pfd_edge_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on),
    .ref_in(ref_div), .vco_in(vco_div),
    .pump(pump), .busy(busy), .ref_lvl(ref_lvl), .vco_lvl(vco_lvl),
    .cmp_done(cmp_done), .cmp_width(cmp_width)
  );

  pfd_lock_qual #(.CNT_W(CNT_W), .LOCK_W(LOCK_W)) lock_i (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .busy(busy),
    .cmp_done(cmp_done), .cmp_width(cmp_width),
    .width_max(cfg_width_max), .run_len(cfg_lock_len), .lock_o(lock_o)
  );

  pfd_out_sel sel_i (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .pol_sel(pol_sel),
    .mon_sel(mon_sel), .busy(busy), .pump(pump),
    .ref_lvl(ref_lvl), .vco_lvl(vco_lvl), .lock_in(lock_o),
    .pump_up(pump_up), .pump_dn(pump_dn), .shared_o(shared_o)
  );

  AST_PUMP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn)); // R2
endmodule

// File: tb/phase_cmp_lockmon_tb_top.sv
`timescale 1ns/1ps
module phase_cmp_lockmon_tb_top;
  localparam int CNT_W  = 8;
  localparam int LOCK_W = 6;

  typedef struct packed {
    logic       pol;
    logic       ref_first;
    logic [3:0] sep;
    logic [3:0] exp_up;
    logic [3:0] exp_dn;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 4'd3, 4'd3, 4'd0},
    '{1'b1, 1'b0, 4'd2, 4'd0, 4'd2},
    '{1'b1, 1'b1, 4'd0, 4'd0, 4'd0},
    '{1'b0, 1'b1, 4'd3, 4'd0, 4'd3},
    '{1'b0, 1'b0, 4'd4, 4'd4, 4'd0},
    '{1'b0, 1'b1, 4'd1, 4'd0, 4'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_div = 1'b0, vco_div = 1'b0, pol_sel = 1'b1, mon_sel = 1'b0, pwr_on = 1'b1;
  logic [CNT_W-1:0]  cfg_width_max = 8'd8;
  logic [LOCK_W-1:0] cfg_lock_len  = 6'd3;
  logic pump_up, pump_dn, lock_o, shared_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  phase_cmp_lockmon #(.CNT_W(CNT_W), .LOCK_W(LOCK_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .vco_div(vco_div),
    .pol_sel(pol_sel), .mon_sel(mon_sel), .pwr_on(pwr_on),
    .cfg_width_max(cfg_width_max), .cfg_lock_len(cfg_lock_len),
    .pump_up(pump_up), .pump_dn(pump_dn), .lock_o(lock_o), .shared_o(shared_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // one comparison: leading edge, trailing edge sep cycles later, counted pump cycles
  task automatic episode(input bit ref_first, input int sep, input int flip_at,
                         output int nu, output int nd, output int nb);
    nu = 0; nd = 0; nb = 0;
    @(negedge clk);
    if (sep == 0) begin ref_div = 1'b1; vco_div = 1'b1; end
    else if (ref_first) ref_div = 1'b1;
    else vco_div = 1'b1;
    for (int i = 0; i < sep + 3; i++) begin
      @(posedge clk); #1;
      nu += int'(pump_up);
      nd += int'(pump_dn);
      nb += int'(pump_up & pump_dn);
      @(negedge clk);
      if (i == flip_at) pol_sel = ~pol_sel;
      if (i == sep - 1) begin
        if (ref_first) vco_div = 1'b1; else ref_div = 1'b1;
      end
      if (i == sep + 1) begin ref_div = 1'b0; vco_div = 1'b0; end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      summary();
    end
  end

  initial begin
    int nu, nd, nb;
    do_reset();
    // R9 reset state
    chk("R9", "pump_up", int'(pump_up), 0);
    chk("R9", "pump_dn", int'(pump_dn), 0);
    chk("R9", "lock_o", int'(lock_o), 0);

    // table walk: R1 / R3 pulse routing and width, R2 exclusivity
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      pol_sel = VECS[v].pol;
      @(negedge clk);
      episode(VECS[v].ref_first, int'(VECS[v].sep), -1, nu, nd, nb);
      chk(VECS[v].pol ? "R1" : "R3", "up cycles", nu, int'(VECS[v].exp_up));
      chk(VECS[v].pol ? "R1" : "R3", "dn cycles", nd, int'(VECS[v].exp_dn));
      chk("R2", "overlap cycles", nb, 0);
    end

    // R4 polarity flip mid-pulse
    pol_sel = 1'b1;
    repeat (2) @(negedge clk);
    episode(1'b1, 3, 0, nu, nd, nb);
    chk("R4", "open pulse keeps up", nu, 3);
    chk("R4", "open pulse no dn", nd, 0);
    episode(1'b1, 2, -1, nu, nd, nb);
    chk("R4", "next cmp swapped dn", nd, 2);
    chk("R4", "next cmp no up", nu, 0);

    // R5 lock run length
    pol_sel = 1'b1;
    do_reset();
    episode(1'b1, 2, -1, nu, nd, nb);
    episode(1'b1, 2, -1, nu, nd, nb);
    chk("R5", "no lock after 2", int'(lock_o), 0);
    episode(1'b0, 2, -1, nu, nd, nb);
    chk("R5", "lock after 3", int'(lock_o), 1);
    // R8 shared shows lock when mon_sel low
    chk("R8", "shared=lock", int'(shared_o), 1);

    // R6 boundary width
    episode(1'b1, 7, -1, nu, nd, nb);
    chk("R6", "width max-1 keeps lock", int'(lock_o), 1);
    episode(1'b1, 8, -1, nu, nd, nb);
    chk("R6", "width max clears lock", int'(lock_o), 0);
    episode(1'b1, 2, -1, nu, nd, nb);
    episode(1'b1, 2, -1, nu, nd, nb);
    chk("R6", "run restarted", int'(lock_o), 0);
    episode(1'b1, 0, -1, nu, nd, nb);
    chk("R5", "coincident counts good", int'(lock_o), 1);

    // R7 power save
    @(negedge clk);
    pwr_on = 1'b0;
    ref_div = 1'b1;
    @(posedge clk); #1;
    chk("R7", "up in psave", int'(pump_up), 0);
    chk("R7", "lock in psave", int'(lock_o), 0);
    chk("R7", "shared in psave", int'(shared_o), 0);
    @(negedge clk);
    vco_div = 1'b1;
    @(posedge clk); #1;
    chk("R7", "dn in psave", int'(pump_dn), 0);
    @(negedge clk);
    pwr_on = 1'b1;
    @(posedge clk); #1;
    chk("R7", "no stale up", int'(pump_up), 0);
    chk("R7", "no stale dn", int'(pump_dn), 0);
    chk("R7", "lock stays clear", int'(lock_o), 0);
    @(negedge clk);
    ref_div = 1'b0; vco_div = 1'b0;
    episode(1'b1, 2, -1, nu, nd, nb);
    chk("R7", "run restarts after wake", int'(lock_o), 0);

    // R8 monitor select
    @(negedge clk);
    mon_sel = 1'b1;
    pol_sel = 1'b1;
    ref_div = 1'b1;
    @(posedge clk); #1;
    chk("R8", "monitor ref high", int'(shared_o), 1);
    @(negedge clk);
    vco_div = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    vco_div = 1'b0;
    pol_sel = 1'b0;
    @(posedge clk); #1;
    chk("R8", "monitor vco low", int'(shared_o), 0);
    @(negedge clk);
    pol_sel = 1'b1;
    @(posedge clk); #1;
    chk("R8", "monitor back to ref", int'(shared_o), 1);
    @(negedge clk);
    ref_div = 1'b0;
    @(posedge clk); #1;
    chk("R8", "monitor ref low", int'(shared_o), 0);

    done = 1'b1;
    summary();
  end
endmodule